// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte Writes

This block is a synthesizable, small-depth model of a synchronous pipelined burst static RAM. Every control, address and write input is registered on the rising clock edge. An access begins on one of two address-start strobes: a processor-style strobe, which is honoured only while the primary chip select is low and always begins a read, or a controller-style strobe, which takes its read or write direction from the write controls sampled at the same edge. Cycles with neither strobe active either advance the burst or hold it on the current word, and their direction comes from the write controls of that edge. Each burst spans four words and covers them in linear or interleaved order.

Data are organised in lanes. Each lane holds eight data bits plus one parity bit. A write updates all lanes when global write is active; otherwise it updates only the lanes whose strobes are low. Read data leave an output register one clock after the read is registered. The asynchronous output enable gates them onto a tristate indication. A deselect turns the outputs off one cycle later. A sleep request stops input sampling and blanks the outputs two cycles after it is sampled, and sampling resumes two cycles after the request is withdrawn.

Top module: `burst_sram`

## Requirements
- R1: The device is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. A start strobe that is honoured while the device is not selected is a deselect.
- R2: A deselect registered at edge k drives `dout_oe` low after edge k+1 and ends the burst, so later advance or hold cycles perform no access.
- R3: While `sel_a_n`=1, `cpu_start_n` is ignored. With `ctl_start_n`=1 such a cycle advances (`burst_adv_n`=0) or holds the current burst.
- R4: `cpu_start_n`=0 on a selected device starts a read at `addr` whatever the write controls are. A write takes place only if the write controls are active at a following continue edge, and a hold edge writes the same word.
- R5: `ctl_start_n`=0 with `cpu_start_n`=1 on a selected device starts a burst at `addr`. Its direction is taken from the write controls at that same edge, and a write produces no output.
- R6: A cycle writes when `wr_all_n`=0, or when `wr_lane_en_n`=0 and at least one bit of `lane_wr_n` is 0. With `wr_lane_en_n`=0 and all lane strobes high the cycle is a read. With `wr_all_n`=1 and `wr_lane_en_n`=1 the lane strobes have no effect.
- R7: `wr_all_n`=0 writes every lane regardless of `lane_wr_n`. Otherwise `lane_wr_n[i]`=0 writes lane i. Lane i is `din[9i+8:9i]`, and its top bit is the lane's parity bit.
- R8: A read registered at edge k appears on `dout` after edge k+1 with `dout_oe`=1 when `out_en_n`=0. `out_en_n`=1 forces `dout_oe` low at once, without a clock.
- R9: With no start strobe, `burst_adv_n`=0 moves the burst to its next word, and `burst_adv_n`=1 keeps the current word.
- R10: The n-th word of a burst keeps the upper address bits of the start address. Its two low bits are (start+n) mod 4 when `seq_mode`=0 (linear) and start XOR n when `seq_mode`=1 (interleaved).
- R11: If `sleep_req`=1 is first sampled at edge k, edges k and k+1 still execute, edges from k+2 on are ignored, and `dout_oe` is low from edge k+2 on. If `sleep_req`=0 is first sampled at edge m, edge m+2 is the first edge sampled again. The burst in progress is discarded, and the array contents are kept.
- R12: After reset `dout_oe` is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| seq_mode | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| cpu_start_n | input | 1 | Processor-style address start strobe, active low |
| ctl_start_n | input | 1 | Controller-style address start strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Primary chip select, active low; also gates `cpu_start_n` |
| sel_b_n | input | 1 | Second chip select, active low |
| sel_c | input | 1 | Third chip select, active high |
| wr_all_n | input | 1 | Global write, active low |
| wr_lane_en_n | input | 1 | Lane-write enable, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| sleep_req | input | 1 | Sleep request, active high |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | LANES*(LANE_W+1) | Write data, one parity bit per lane |
| dout | output | LANES*(LANE_W+1) | Registered read data |
| dout_oe | output | 1 | High when `dout` is driven; low means high impedance |

## Verification
The assertions assume that `seq_mode` changes only while no burst is active. They also assume that the synchronous inputs are stable around each rising edge, and that `out_en_n` is the only input allowed to change between edges. The bench drives every input one nanosecond after the edge and changes `seq_mode` only between bursts. It toggles `out_en_n` in the middle of a cycle only when checking the asynchronous gating. It also assumes that the array holds no meaningful contents after reset, so every address is written before it is read back.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_START,
    CYC_NEXT,
    CYC_HOLD
  } cyc_kind_e;

  typedef struct packed {
    cyc_kind_e kind;
    logic      is_wr;
    logic      from_cpu;
  } cyc_t;

  // Low two address bits of the burst word at position pos.
  function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                          input logic [1:0] pos,
                                          input logic       ilv);
    return ilv ? (base ^ pos) : (base + pos);
  endfunction

endpackage

// File: rtl/bsram_cycle_dec.sv
module bsram_cycle_dec
  import bsram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             cpu_start_n,
  input  logic             ctl_start_n,
  input  logic             burst_adv_n,
  input  logic             sel_a_n,
  input  logic             sel_b_n,
  input  logic             sel_c,
  input  logic             wr_all_n,
  input  logic             wr_lane_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  output cyc_t             cyc,
  output logic [LANES-1:0] lane_mask
);

  logic selected;
  logic wr_req;
  logic cpu_live;

  assign selected = !sel_a_n && !sel_b_n && sel_c;
  assign wr_req   = !wr_all_n || (!wr_lane_en_n && (lane_wr_n != '1));
  // Processor strobe only counts while the primary select is low (R3).
  assign cpu_live = !cpu_start_n && !sel_a_n;

  always_comb begin
    cyc.kind     = CYC_IDLE;
    cyc.is_wr    = 1'b0;
    cyc.from_cpu = 1'b0;
    if (cpu_live) begin
      if (selected) begin
        cyc.kind     = CYC_START;
        cyc.from_cpu = 1'b1;   // always a read (R4)
      end else begin
        cyc.kind = CYC_DESEL;
      end
    end else if (!ctl_start_n) begin
      if (selected) begin
        cyc.kind  = CYC_START;
        cyc.is_wr = wr_req;    // same-edge direction (R5)
      end else begin
        cyc.kind = CYC_DESEL;
      end
    end else begin
      cyc.kind  = burst_adv_n ? CYC_HOLD : CYC_NEXT;
      cyc.is_wr = wr_req;
    end
  end

  // Global write overrides the lane strobes (R7).
  assign lane_mask = wr_all_n ? ~lane_wr_n : '1;

endmodule

// File: rtl/bsram_burst_gen.sv
module bsram_burst_gen
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              seq_ilv,
  input  cyc_t              cyc,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic              op_valid
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              live_q;
  logic [1:0]        pos;

  always_comb begin
    pos = (cyc.kind == CYC_NEXT) ? cnt_q + 2'd1 : cnt_q;
    if (cyc.kind == CYC_START)
      cyc_addr = addr;
    else
      cyc_addr = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], pos, seq_ilv)};
    op_valid = go && ((cyc.kind == CYC_START) ||
               (live_q && (cyc.kind == CYC_NEXT || cyc.kind == CYC_HOLD)));
  end

  always_ff @(posedge clk) begin
    if (rst || !go) begin
      live_q <= 1'b0;
      cnt_q  <= 2'd0;
    end else begin
      case (cyc.kind)
        CYC_START: begin
          live_q <= 1'b1;
          cnt_q  <= 2'd0;
        end
        CYC_DESEL: live_q <= 1'b0;
        CYC_NEXT:  if (live_q) cnt_q <= cnt_q + 2'd1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (go && cyc.kind == CYC_START) base_q <= addr;
  end

  p_hold_keeps_word_r9: assert property (@(posedge clk) disable iff (rst)
    go && live_q && cyc.kind == CYC_HOLD |=> $stable(cnt_q));

  p_next_steps_word_r9: assert property (@(posedge clk) disable iff (rst)
    go && live_q && cyc.kind == CYC_NEXT |=> cnt_q == $past(cnt_q) + 2'd1);

endmodule

// File: rtl/bsram_lane_array.sv
module bsram_lane_array #(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 2,
  parameter int LANE_BITS = 9
) (
  input  logic                       clk,
  input  logic [LANES-1:0]           we,
  input  logic [ADDR_W-1:0]          waddr,
  input  logic [LANES*LANE_BITS-1:0] wdata,
  input  logic                       re,
  input  logic [ADDR_W-1:0]          raddr,
  output logic [LANES*LANE_BITS-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_BITS-1:0] mem [DEPTH];
    logic [LANE_BITS-1:0] q;

    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_BITS +: LANE_BITS];
      if (re)    q <= mem[raddr];
    end

    assign rdata[g*LANE_BITS +: LANE_BITS] = q;
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            seq_mode,
  input  logic                            cpu_start_n,
  input  logic                            ctl_start_n,
  input  logic                            burst_adv_n,
  input  logic                            sel_a_n,
  input  logic                            sel_b_n,
  input  logic                            sel_c,
  input  logic                            wr_all_n,
  input  logic                            wr_lane_en_n,
  input  logic [LANES-1:0]                lane_wr_n,
  input  logic                            sleep_req,
  input  logic                            out_en_n,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [LANES*(LANE_W+1)-1:0]     din,
  output logic [LANES*(LANE_W+1)-1:0]     dout,
  output logic                            dout_oe
);

  localparam int LANE_BITS = LANE_W + 1;

  logic              slp_q1, slp_q2;
  logic              asleep, go;
  cyc_t              cyc;
  logic [LANES-1:0]  lane_mask;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] cyc_addr;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              op_valid, rd_op;
  logic              rd_pend, dout_vld;

  // Two-stage sleep latency in both directions (R11).
  always_ff @(posedge clk) begin
    if (rst) begin
      slp_q1 <= 1'b0;
      slp_q2 <= 1'b0;
    end else begin
      slp_q1 <= sleep_req;
      slp_q2 <= slp_q1;
    end
  end

  assign asleep = slp_q2;
  assign go     = !asleep;

  bsram_cycle_dec #(.LANES(LANES)) u_dec (
    .cpu_start_n (cpu_start_n),
    .ctl_start_n (ctl_start_n),
    .burst_adv_n (burst_adv_n),
    .sel_a_n     (sel_a_n),
    .sel_b_n     (sel_b_n),
    .sel_c       (sel_c),
    .wr_all_n    (wr_all_n),
    .wr_lane_en_n(wr_lane_en_n),
    .lane_wr_n   (lane_wr_n),
    .cyc         (cyc),
    .lane_mask   (lane_mask)
  );

  bsram_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .seq_ilv (seq_mode),
    .cyc     (cyc),
    .addr    (addr),
    .cyc_addr(cyc_addr),
    .op_valid(op_valid)
  );

  assign lane_we = (op_valid && cyc.is_wr) ? lane_mask : '0;
  assign rd_op   = op_valid && !cyc.is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend  <= 1'b0;
      dout_vld <= 1'b0;
    end else begin
      rd_pend  <= rd_op;
      dout_vld <= rd_pend && go;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_op) rd_addr_q <= cyc_addr;
  end

  bsram_lane_array #(
    .ADDR_W   (ADDR_W),
    .LANES    (LANES),
    .LANE_BITS(LANE_BITS)
  ) u_array (
    .clk  (clk),
    .we   (lane_we),
    .waddr(cyc_addr),
    .wdata(din),
    .re   (rd_pend),
    .raddr(rd_addr_q),
    .rdata(dout)
  );

  assign dout_oe = dout_vld && !out_en_n;

  p_sleep_blanks_out_r11: assert property (@(posedge clk) disable iff (rst)
    asleep && $past(asleep) |-> !dout_oe);

  p_desel_blanks_out_r2: assert property (@(posedge clk) disable iff (rst)
    go && cyc.kind == CYC_DESEL |=> ##1 !dout_vld);

  p_read_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    rd_op && !slp_q1 |=> ##1 dout_vld);

  p_cpu_start_reads_r4: assert property (@(posedge clk) disable iff (rst)
    cyc.kind == CYC_START && cyc.from_cpu |-> lane_we == '0);

endmodule

// File: tb/test_burst_sram.sv
module test_burst_sram;
  localparam int AW = 6;
  localparam int LN = 2;
  localparam int LB = 9;
  localparam int DW = LN * LB;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, seq_mode, cpu_start_n, ctl_start_n, burst_adv_n;
  logic sel_a_n, sel_b_n, sel_c, wr_all_n, wr_lane_en_n;
  logic [LN-1:0] lane_wr_n;
  logic sleep_req, out_en_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic dout_oe;

  burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LB-1)) i_burst_sram (
    .clk(clk), .rst(rst), .seq_mode(seq_mode), .cpu_start_n(cpu_start_n),
    .ctl_start_n(ctl_start_n), .burst_adv_n(burst_adv_n), .sel_a_n(sel_a_n),
    .sel_b_n(sel_b_n), .sel_c(sel_c), .wr_all_n(wr_all_n),
    .wr_lane_en_n(wr_lane_en_n), .lane_wr_n(lane_wr_n), .sleep_req(sleep_req),
    .out_en_n(out_en_n), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] ref_mem [64];

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_oe(string tag, logic exp);
    n_chk++;
    if (dout_oe !== exp) begin
      n_bad++;
      $display("FAIL %s: dout_oe got %b expected %b", tag, dout_oe, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                          input logic [LN-1:0] m);
    logic [DW-1:0] r = o;
    for (int i = 0; i < LN; i++) if (m[i]) r[i*LB +: LB] = n[i*LB +: LB];
    return r;
  endfunction

  function automatic logic [AW-1:0] baddr(input logic [AW-1:0] b, input int n, input logic ilv);
    logic [1:0] s = 2'(n);
    return {b[AW-1:2], ilv ? (b[1:0] ^ s) : (b[1:0] + s)};
  endfunction

  task automatic quiet();
    cpu_start_n = 1; ctl_start_n = 1; burst_adv_n = 1;
    wr_all_n = 1; wr_lane_en_n = 1; lane_wr_n = '1;
    sel_a_n = 0; sel_b_n = 0; sel_c = 1;
  endtask

  task automatic ctl_start(logic [AW-1:0] a);
    quiet();
    ctl_start_n = 0;
    addr = a;
  endtask

  task automatic wr_word(logic [AW-1:0] a, logic [DW-1:0] d);
    ctl_start(a);
    wr_all_n = 0;
    din = d;
    step();
    quiet();
    ref_mem[a] = d;
  endtask

  task automatic rd_check(string tag, logic [AW-1:0] a);
    ctl_start(a);
    step();
    quiet();
    step();
    check(tag, dout, ref_mem[a]);
    check_oe(tag, 1'b1);
  endtask

  // R12: reset state
  task automatic t_reset();
    check_oe("R12 after reset", 1'b0);
    quiet(); burst_adv_n = 0;
    step(); step();
    check_oe("R12 no burst after reset", 1'b0);
  endtask

  // R5: controller-strobe writes, read back
  task automatic t_fill();
    for (int a = 0; a < 64; a++) begin
      wr_word(AW'(a), DW'(32'(a) * 32'd40503 + 32'h1357));
      check_oe("R5 write gives no output", 1'b0);
    end
    rd_check("R5 read back 0", 0);
    rd_check("R5 read back 63", 63);
  endtask

  // R6, R7: lane writes and write decode
  task automatic t_lanes();
    ctl_start(5); wr_lane_en_n = 0; lane_wr_n = 2'b10; din = 18'h3FFFF;
    step(); quiet();
    ref_mem[5] = merge(ref_mem[5], 18'h3FFFF, 2'b01);
    rd_check("R7 lane0 only", 5);

    ctl_start(6); wr_lane_en_n = 0; lane_wr_n = 2'b01; din = 18'h20000;
    step(); quiet();
    ref_mem[6] = merge(ref_mem[6], 18'h20000, 2'b10);
    rd_check("R7 lane1 with parity", 6);

    ctl_start(7); wr_lane_en_n = 0; lane_wr_n = 2'b11; din = 18'h0AAAA;
    step(); quiet(); step();
    check("R6 lane enable without strobes reads", dout, ref_mem[7]);
    check_oe("R6 lane enable without strobes reads", 1'b1);

    ctl_start(8); lane_wr_n = 2'b00; din = 18'h05555;
    step(); quiet(); step();
    check("R6 strobes ignored without enable", dout, ref_mem[8]);
    rd_check("R6 word 8 unchanged", 8);

    ctl_start(9); wr_all_n = 0; wr_lane_en_n = 0; lane_wr_n = 2'b11; din = 18'h2C3A5;
    step(); quiet();
    ref_mem[9] = 18'h2C3A5;
    rd_check("R7 global write all lanes", 9);
  endtask

  // R9, R10: four-word read burst
  task automatic t_burst(string tag, logic [AW-1:0] base, logic ilv);
    seq_mode = ilv;
    ctl_start(base);
    step();
    for (int i = 0; i < 4; i++) begin
      quiet();
      burst_adv_n = (i < 3) ? 1'b0 : 1'b1;
      step();
      check(tag, dout, ref_mem[baddr(base, i, ilv)]);
    end
    quiet();
    seq_mode = 0;
  endtask

  // R9: write burst with a suspended cycle
  task automatic t_write_suspend();
    ctl_start(20); wr_all_n = 0; din = 18'h11111;
    step();
    quiet(); wr_lane_en_n = 0; lane_wr_n = 2'b01; din = 18'h2EEEE;
    step();
    quiet(); burst_adv_n = 0; wr_all_n = 0; din = 18'h0F0F0;
    step();
    quiet();
    ref_mem[20] = merge(18'h11111, 18'h2EEEE, 2'b10);
    ref_mem[21] = 18'h0F0F0;
    rd_check("R9 suspend writes same word", 20);
    rd_check("R9 advance writes next word", 21);
  endtask

  // R4: processor strobe reads, following edge writes
  task automatic t_cpu_start();
    logic [DW-1:0] old = ref_mem[24];
    quiet(); cpu_start_n = 0; addr = 24; wr_all_n = 0; din = 18'h3AAAA;
    step();
    quiet(); wr_all_n = 0; din = 18'h15A5A;
    step();
    check("R4 processor start is a read", dout, old);
    check_oe("R4 processor start is a read", 1'b1);
    quiet();
    ref_mem[24] = 18'h15A5A;
    rd_check("R4 following edge writes", 24);
  endtask

  // R3: processor strobe gated by primary select
  task automatic t_cpu_gate();
    ctl_start(28);
    step();
    quiet(); sel_a_n = 1; cpu_start_n = 0; addr = 40; burst_adv_n = 0;
    step();
    check("R3 first word", dout, ref_mem[28]);
    quiet();
    step();
    check("R3 gated strobe continued burst", dout, ref_mem[29]);
    check_oe("R3 gated strobe continued burst", 1'b1);
  endtask

  // R1, R2: deselect
  task automatic t_deselect();
    ctl_start(32);
    step();
    quiet(); cpu_start_n = 0; sel_c = 0;
    step();
    check("R2 read before deselect", dout, ref_mem[32]);
    quiet(); burst_adv_n = 0;
    step();
    check_oe("R2 deselect blanks output", 1'b0);
    step();
    check_oe("R2 burst ended by deselect", 1'b0);

    ctl_start(33);
    step();
    ctl_start(34); sel_b_n = 1;
    step();
    check("R1 read before deselect", dout, ref_mem[33]);
    quiet();
    step();
    check_oe("R1 second select high deselects", 1'b0);

    ctl_start(35); sel_a_n = 1;
    step(); quiet(); step();
    check_oe("R1 primary select high deselects", 1'b0);
  endtask

  // R8: asynchronous output enable
  task automatic t_out_enable();
    ctl_start(36);
    step(); quiet(); step();
    check("R8 read data", dout, ref_mem[36]);
    out_en_n = 1; #1;
    check_oe("R8 output enable off", 1'b0);
    out_en_n = 0; #1;
    check_oe("R8 output enable on", 1'b1);
  endtask

  // R11: sleep entry and exit
  task automatic t_sleep();
    ctl_start(40);
    step();
    quiet(); burst_adv_n = 0; sleep_req = 1;
    step();
    check("R11 edge of sampling still runs", dout, ref_mem[40]);
    step();
    check("R11 next edge still runs", dout, ref_mem[41]);
    ctl_start(40); wr_all_n = 0; din = 18'h3DEAD;
    step();
    check_oe("R11 output off in sleep", 1'b0);
    step();
    check_oe("R11 output off in sleep", 1'b0);
    sleep_req = 0;
    step();
    check_oe("R11 still asleep after release", 1'b0);
    step();
    check_oe("R11 still asleep after release", 1'b0);
    quiet(); burst_adv_n = 0;
    step();
    check_oe("R11 continue after wake", 1'b0);
    ctl_start(41);
    step();
    check_oe("R11 burst discarded by sleep", 1'b0);
    quiet();
    step();
    check("R11 read after wake", dout, ref_mem[41]);
    rd_check("R11 contents kept through sleep", 40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1; seq_mode = 0; sleep_req = 0; out_en_n = 0;
    addr = '0; din = '0;
    quiet();
    repeat (3) step();
    rst = 0;
    step();
    t_reset();
    t_fill();
    t_lanes();
    t_burst("R10 linear from 3", 7, 1'b0);
    t_burst("R10 linear from 1", 13, 1'b0);
    t_burst("R10 interleaved from 1", 9, 1'b1);
    t_burst("R10 interleaved from 3", 15, 1'b1);
    t_write_suspend();
    t_cpu_start();
    t_cpu_gate();
    t_deselect();
    t_out_enable();
    t_sleep();
    summary();
    $finish;
  end

endmodule